// File: doc/BRIEF.md
# Command Checksum Handshake Controller

This block is the device-side controller for short command frames that a host sends one byte at a time. It receives bytes on a valid/ready stream. It decodes the first byte of each frame to find the frame length and kind, and adds up every byte of the frame modulo 256. It returns that sum to the host and holds the frame until the host confirms it. After confirmation it hands the decoded frame to a downstream transmitter with a one-cycle start pulse. When the transmitter reports completion, the block sends a fixed ready byte. The serial link, the line modulation and any dim timing sit outside the block and are seen only through the start/done pair.

Two one-byte commands switch a ring-enable flag on and off. They follow the same echo and confirm exchange, but they never start the transmitter. The flag comes out of reset enabled.

The controller is one state machine with seven states:
- IDLE: waits for a frame.
- BODY: collects the code, data and command bytes.
- SUM: offers the checksum.
- CONFIRM: waits for the host's verdict.
- LAUNCH: issues the start pulse.
- BUSY: waits for the done pulse.
- READY: offers the ready byte.

Its transitions are:
- IDLE to BODY when a valid header arrives.
- IDLE to SUM when a ring command arrives.
- BODY to SUM after the last byte of the frame.
- BODY to IDLE when an extended code byte is bad.
- SUM to CONFIRM once the host accepts the checksum.
- CONFIRM to LAUNCH on 0x00 for a frame.
- CONFIRM to READY on 0x00 for a ring command.
- CONFIRM to BODY on a fresh header.
- CONFIRM to IDLE on any other byte.
- LAUNCH to BUSY unconditionally.
- BUSY to READY on done.
- READY to IDLE once the host accepts the ready byte.

Top module: `cmd_handshake_ctrl`

## Requirements
- R1: After reset, rx_ready is 1, tx_valid is 0, xmit_start is 0 and ring_en is 1.
- R2: A header is any byte with bit 2 set, bit 0 clear and a dim count (bits 7..3) of at most 22. It opens a standard frame of two bytes: the header and one code byte. Bit 1 is the function flag, bit 0 the extended flag and bits 7..3 the dim count. These appear on xmit_func, xmit_ext and xmit_dim.
- R3: The header 0x07 opens an extended frame of four bytes: header, code, data and command. If the code byte's low nibble is not 0111, the frame is dropped at once with no checksum and the block returns to idle.
- R4: After the last byte of a frame, the block offers the sum of all the frame's bytes, truncated to 8 bits, on tx_data.
- R5: When 0x00 arrives while a frame awaits confirmation, the block raises xmit_start for exactly one cycle. While it does, xmit_code, xmit_data and xmit_cmd carry the frame's bytes; data and command are 0 for a standard frame.
- R6: When a valid header arrives while a frame awaits confirmation, the pending frame is discarded and the new frame is received and summed in its place.
- R7: When any byte other than 0x00 or a valid header arrives while awaiting confirmation, the pending frame or command is dropped. No start pulse follows and the ring flag does not change.
- R8: After a done pulse from the transmitter, the block offers 0x55 and then returns to idle.
- R9: 0xEB (ring on) and 0xDB (ring off) are each echoed as their own checksum. After a 0x00 confirmation, ring_en takes the new value, 0x55 is offered, and no start pulse is issued.
- R10: In idle, a byte that is neither a valid header nor a ring command is ignored. This covers a byte with bit 2 clear, a dim count above 22, and an extended header other than 0x07.
- R11: An offered tx byte stays valid and unchanged until tx_ready accepts it. No rx byte is accepted while a tx byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Host byte valid |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Block accepts a host byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte (checksum or 0x55) |
| tx_ready | input | 1 | Host accepts the reply byte |
| xmit_start | output | 1 | One-cycle transmit request |
| xmit_ext | output | 1 | Frame is extended |
| xmit_func | output | 1 | Code byte is a function |
| xmit_dim | output | 5 | Dim count from the header |
| xmit_code | output | 8 | Code byte |
| xmit_data | output | 8 | Extended data byte |
| xmit_cmd | output | 8 | Extended command byte |
| xmit_done | input | 1 | Transmission finished pulse |
| ring_en | output | 1 | Ring-enable flag |

## Verification
The embedded assertions check four properties on every cycle:
- the start pulse is one cycle wide;
- a reply byte is held until accepted, and no host byte is taken while one is offered;
- an extended launch carries a code nibble of 0111;
- the ring flag moves only on the clock after a confirming 0x00.

Some behaviours show only in the bench's scenarios. These are the checksum values, retransmission with a fresh header, the silent drop on a stray byte, the ignored idle bytes, the dim boundary of 22, and the exact fields handed to the transmitter. The bench checks them by comparing the reply stream and the start events against its own expectations.

// File: rtl/cmd_hs_pkg.sv
package cmd_hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_SUM,
        ST_CONFIRM,
        ST_LAUNCH,
        ST_BUSY,
        ST_READY
    } hs_state_t;

    typedef enum logic [1:0] {
        FK_STD,
        FK_EXT,
        FK_RING_ON,
        FK_RING_OFF
    } frame_kind_t;
endpackage

// File: rtl/cmd_hs_classify.sv
module cmd_hs_classify #(
    parameter int          DW       = 8,
    parameter int          DIM_MAX  = 22,
    parameter logic [7:0]  EXT_HDR  = 8'h07,
    parameter logic [7:0]  RING_ON  = 8'hEB,
    parameter logic [7:0]  RING_OFF = 8'hDB
) (
    input  logic [DW-1:0] din,
    output logic          hdr_ok,
    output logic          hdr_ext,
    output logic          ring_on,
    output logic          ring_off
);
    localparam int DIM_W = DW - 3;

    logic [DIM_W-1:0] dim;

    always_comb begin
        dim      = din[DW-1:3];
        hdr_ext  = din[0];
        ring_on  = (din == DW'(RING_ON));
        ring_off = (din == DW'(RING_OFF));
        if (!din[2])
            hdr_ok = 1'b0;
        else if (din[0])
            hdr_ok = (din == DW'(EXT_HDR));
        else
            hdr_ok = (int'(dim) <= DIM_MAX);
    end
endmodule

// File: rtl/cmd_hs_sum.sv
module cmd_hs_sum #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          accum,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum <= '0;
        else if (load)
            sum <= din;
        else if (accum)
            sum <= sum + din;
    end
endmodule

// File: rtl/cmd_handshake_ctrl.sv
module cmd_handshake_ctrl
    import cmd_hs_pkg::*;
#(
    parameter int          DW         = 8,
    parameter int          DIM_MAX    = 22,
    parameter logic [7:0]  EXT_HDR    = 8'h07,
    parameter logic [3:0]  EXT_FUNC   = 4'h7,
    parameter logic [7:0]  ACK_BYTE   = 8'h00,
    parameter logic [7:0]  READY_BYTE = 8'h55,
    parameter logic [7:0]  RING_ON    = 8'hEB,
    parameter logic [7:0]  RING_OFF   = 8'hDB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    input  logic          tx_ready,
    output logic          xmit_start,
    output logic          xmit_ext,
    output logic          xmit_func,
    output logic [DW-4:0] xmit_dim,
    output logic [DW-1:0] xmit_code,
    output logic [DW-1:0] xmit_data,
    output logic [DW-1:0] xmit_cmd,
    input  logic          xmit_done,
    output logic          ring_en
);
    localparam int CNT_W    = 2;
    localparam int STD_BODY = 1;
    localparam int EXT_BODY = 3;

    hs_state_t   state_q, state_d;
    frame_kind_t kind_q;
    logic [CNT_W-1:0] left_q, idx_q;
    logic [DW-1:0]    hdr_q, code_q, data_q, cmd_q;
    logic [DW-1:0]    sum;
    logic             ring_q;
    logic             hdr_ok, hdr_ext, is_ring_on, is_ring_off;
    logic             rx_fire, sum_load, sum_accum, bad_ext;

    cmd_hs_classify #(
        .DW(DW), .DIM_MAX(DIM_MAX), .EXT_HDR(EXT_HDR),
        .RING_ON(RING_ON), .RING_OFF(RING_OFF)
    ) u_classify (
        .din(rx_data), .hdr_ok(hdr_ok), .hdr_ext(hdr_ext),
        .ring_on(is_ring_on), .ring_off(is_ring_off)
    );

    cmd_hs_sum #(.DW(DW)) u_sum (
        .clk(clk), .rst_n(rst_n), .load(sum_load),
        .accum(sum_accum), .din(rx_data), .sum(sum)
    );

    assign rx_fire   = rx_valid && rx_ready;
    assign bad_ext   = (kind_q == FK_EXT) && (idx_q == '0) && (rx_data[3:0] != EXT_FUNC);
    assign sum_load  = rx_fire && (((state_q == ST_IDLE) && (hdr_ok || is_ring_on || is_ring_off))
                                 || ((state_q == ST_CONFIRM) && hdr_ok && (rx_data != DW'(ACK_BYTE))));
    assign sum_accum = rx_fire && (state_q == ST_BODY);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (rx_fire) begin
                    if (hdr_ok)                        state_d = ST_BODY;
                    else if (is_ring_on || is_ring_off) state_d = ST_SUM;
                end
            ST_BODY:
                if (rx_fire) begin
                    if (bad_ext)                     state_d = ST_IDLE;
                    else if (left_q == CNT_W'(1))    state_d = ST_SUM;
                end
            ST_SUM:
                if (tx_ready) state_d = ST_CONFIRM;
            ST_CONFIRM:
                if (rx_fire) begin
                    if (rx_data == DW'(ACK_BYTE))
                        state_d = (kind_q == FK_RING_ON || kind_q == FK_RING_OFF) ? ST_READY : ST_LAUNCH;
                    else if (hdr_ok)
                        state_d = ST_BODY;
                    else
                        state_d = ST_IDLE;
                end
            ST_LAUNCH:
                state_d = ST_BUSY;
            ST_BUSY:
                if (xmit_done) state_d = ST_READY;
            ST_READY:
                if (tx_ready) state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame capture and ring flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= FK_STD;
            left_q <= '0;
            idx_q  <= '0;
            hdr_q  <= '0;
            code_q <= '0;
            data_q <= '0;
            cmd_q  <= '0;
            ring_q <= 1'b1;
        end else if (sum_load) begin
            idx_q  <= '0;
            hdr_q  <= rx_data;
            code_q <= '0;
            data_q <= '0;
            cmd_q  <= '0;
            if (is_ring_on)       kind_q <= FK_RING_ON;
            else if (is_ring_off) kind_q <= FK_RING_OFF;
            else if (hdr_ext)     kind_q <= FK_EXT;
            else                  kind_q <= FK_STD;
            left_q <= hdr_ext ? CNT_W'(EXT_BODY) : CNT_W'(STD_BODY);
        end else if (sum_accum) begin
            idx_q  <= idx_q + CNT_W'(1);
            left_q <= left_q - CNT_W'(1);
            case (idx_q)
                2'd0:    code_q <= rx_data;
                2'd1:    data_q <= rx_data;
                default: cmd_q  <= rx_data;
            endcase
        end else if (rx_fire && state_q == ST_CONFIRM && rx_data == DW'(ACK_BYTE)) begin
            if (kind_q == FK_RING_ON)       ring_q <= 1'b1;
            else if (kind_q == FK_RING_OFF) ring_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rx_ready   = (state_q == ST_IDLE) || (state_q == ST_BODY) || (state_q == ST_CONFIRM);
        tx_valid   = (state_q == ST_SUM) || (state_q == ST_READY);
        tx_data    = (state_q == ST_READY) ? DW'(READY_BYTE) : sum;
        xmit_start = (state_q == ST_LAUNCH);
        xmit_ext   = hdr_q[0];
        xmit_func  = hdr_q[1];
        xmit_dim   = hdr_q[DW-1:3];
        xmit_code  = code_q;
        xmit_data  = data_q;
        xmit_cmd   = cmd_q;
        ring_en    = ring_q;
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_start |=> !xmit_start); // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R11
    AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready); // R11
    AST_EXT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_start && xmit_ext |-> xmit_code[3:0] == EXT_FUNC); // R3
    AST_RING_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ring_en) |-> $past(rx_valid && rx_ready && rx_data == DW'(ACK_BYTE))); // R9
endmodule

// File: tb/cmd_handshake_ctrl_test.sv
module cmd_handshake_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       xmit_start, xmit_ext, xmit_func;
    logic [4:0] xmit_dim;
    logic [7:0] xmit_code, xmit_data, xmit_cmd;
    logic       xmit_done = 1'b0;
    logic       ring_en;

    int n_checks = 0;
    int n_fail   = 0;
    int n_starts = 0;
    int exp_starts = 0;
    int dly = 0;
    int txr_cnt = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] e_hdr, e_code, e_data, e_cmd;

    always #10 clk = ~clk;

    cmd_handshake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .xmit_start(xmit_start), .xmit_ext(xmit_ext),
        .xmit_func(xmit_func), .xmit_dim(xmit_dim), .xmit_code(xmit_code),
        .xmit_data(xmit_data), .xmit_cmd(xmit_cmd), .xmit_done(xmit_done),
        .ring_en(ring_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // host accepts replies on an irregular pattern
    always @(posedge clk) begin
        txr_cnt <= txr_cnt + 1;
        tx_ready <= (txr_cnt % 3) != 0;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0)
                check(1'b0, "R11 unexpected reply", int'(tx_data), -1);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(tx_data == e, t, int'(tx_data), int'(e));
            end
        end
    end

    // transmitter model
    always @(negedge clk) begin
        xmit_done = 1'b0;
        if (dly != 0) begin
            dly = dly - 1;
            if (dly == 0) xmit_done = 1'b1;
        end
        if (rst_n && xmit_start) begin
            n_starts++;
            dly = 4;
            check(xmit_ext == e_hdr[0], "R2 ext flag", int'(xmit_ext), int'(e_hdr[0]));
            check(xmit_func == e_hdr[1], "R2 func flag", int'(xmit_func), int'(e_hdr[1]));
            check(xmit_dim == e_hdr[7:3], "R2 dim", int'(xmit_dim), int'(e_hdr[7:3]));
            check(xmit_code == e_code, "R5 code", int'(xmit_code), int'(e_code));
            check(xmit_data == e_data, "R5 data", int'(xmit_data), int'(e_data));
            check(xmit_cmd == e_cmd, "R5 cmd", int'(xmit_cmd), int'(e_cmd));
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_tx(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic frame2(input logic [7:0] h, input logic [7:0] c);
        e_hdr = h; e_code = c; e_data = 8'h00; e_cmd = 8'h00;
        expect_tx(h + c, "R4 checksum");
        put(h); put(c);
    endtask

    task automatic frame4(input logic [7:0] h, input logic [7:0] c,
                          input logic [7:0] d, input logic [7:0] m);
        e_hdr = h; e_code = c; e_data = d; e_cmd = m;
        expect_tx(h + c + d + m, "R3 extended checksum");
        put(h); put(c); put(d); put(m);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic confirm(input bit launches);
        expect_tx(8'h55, "R8 ready byte");
        if (launches) exp_starts++;
        put(8'h00);
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rx_ready == 1'b1, "R1 rx_ready", int'(rx_ready), 1);
        check(tx_valid == 1'b0, "R1 tx_valid", int'(tx_valid), 0);
        check(xmit_start == 1'b0, "R1 xmit_start", int'(xmit_start), 0);
        check(ring_en == 1'b1, "R1 ring_en", int'(ring_en), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4 R5 R8: standard address frame
        frame2(8'h04, 8'h66);
        confirm(1'b1);
        check(n_starts == exp_starts, "R5 start count", n_starts, exp_starts);

        // R6: fresh header replaces the pending frame
        expect_tx(8'h72, "R6 first checksum");
        put(8'h04); put(8'h6E);
        frame2(8'h86, 8'h64);
        confirm(1'b1);
        check(n_starts == exp_starts, "R6 single start", n_starts, exp_starts);

        // R3: extended frame
        frame4(8'h07, 8'h37, 8'hFF, 8'h55);
        confirm(1'b1);

        // R3: bad extended code nibble drops frame
        put(8'h07); put(8'h35);
        repeat (4) @(negedge clk);
        check(rx_ready == 1'b1, "R3 dropped to idle", int'(rx_ready), 1);
        check(exp_q.size() == 0, "R3 no reply", exp_q.size(), 0);
        frame2(8'h04, 8'h66);
        confirm(1'b1);
        check(n_starts == exp_starts, "R3 start count", n_starts, exp_starts);

        // R10: ignored idle bytes
        put(8'h11); put(8'hBC); put(8'h0F);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && n_starts == exp_starts, "R10 ignored", n_starts, exp_starts);
        frame2(8'h06, 8'h62);
        confirm(1'b1);

        // R7: stray byte while awaiting confirmation
        expect_tx(8'h6A, "R7 checksum");
        put(8'h04); put(8'h66);
        put(8'h11);
        put(8'h00);
        repeat (10) @(negedge clk);
        check(n_starts == exp_starts, "R7 no start", n_starts, exp_starts);

        // R2: dim boundary 22
        frame2(8'hB4, 8'h66);
        confirm(1'b1);

        // R9: ring off then on
        expect_tx(8'hDB, "R9 echo off");
        put(8'hDB);
        confirm(1'b0);
        check(ring_en == 1'b0, "R9 ring off", int'(ring_en), 0);
        expect_tx(8'hEB, "R9 echo on");
        put(8'hEB);
        confirm(1'b0);
        check(ring_en == 1'b1, "R9 ring on", int'(ring_en), 1);
        check(n_starts == exp_starts, "R9 no start", n_starts, exp_starts);

        // R7: ring command dropped by stray byte
        expect_tx(8'hDB, "R7 ring echo");
        put(8'hDB);
        put(8'h22);
        repeat (6) @(negedge clk);
        check(ring_en == 1'b1, "R7 ring kept", int'(ring_en), 1);

        drain();
        check(exp_q.size() == 0, "R11 all replies seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule